// File: doc/BRIEF.md
# Bus cycle termination resolver

This block works out how an asynchronous processor bus cycle ends. On each rising edge of an even bus state it samples three active-low termination inputs: the data-transfer acknowledge lines, bus-error and halt. The sample at one even state (N) is compared with the sample two states later (N+2). When the pair of samples matches a known termination pattern, the block reports one outcome for one clock: normal continue, normal end followed by a halt stall, bus-error exception, or retry. If the pair matches no pattern, the cycle has wait states. The newer sample then becomes the reference point N and sampling goes on.

After a halt stall or a retry, the block holds a pending status for as long as halt stays asserted. When halt is released it clears that status and gives a one-clock resume pulse. Two checks run beside the classifier. The first raises a protocol flag when the synchronous terminate input and any acknowledge line are asserted in the same clock. The second warns when acknowledge or bus-error, left over from the cycle that just ended, is still asserted at the first even sample of the next cycle. The surrounding state sequencer supplies a cycle-start pulse and an even-state strobe, and it acts on the outcome outputs.

Top module: `bus_term_resolver`

## Requirements
- R1: An outcome is reported as `outcome_vld` high for exactly one clock, in the clock after the even strobe that completes a matching pattern. The pattern is completed by the N+2 sample. `outcome` is one-hot while `outcome_vld` is high and all zero otherwise. The bit encoding is: bit 0 continue, bit 1 halt stall, bit 2 bus error, bit 3 retry.
- R2: Acknowledge asserted at both N and N+2, with bus-error and halt negated at both, gives continue.
- R3: Acknowledge asserted at both points, bus-error negated at both, and halt asserted at N+2 (asserted or not at N) gives halt stall.
- R4: Bus-error asserted at both points with halt negated at both gives bus error, whatever the acknowledge lines do.
- R5: Acknowledge asserted at N, bus-error negated at N and asserted at N+2, with halt negated at both, gives bus error.
- R6: Bus-error and halt both asserted at N and at N+2 gives retry.
- R7: Acknowledge asserted at N with bus-error and halt negated, then bus-error and halt both asserted at N+2, gives retry.
- R8: A sample pair that matches none of R2 to R7 gives no outcome. The N+2 sample becomes the new N, and a later even strobe in the same cycle can still terminate it.
- R9: After a halt-stall outcome `stall_pend` is high, and after a retry outcome `retry_pend` is high. The status stays high every clock while halt is sampled asserted. In the clock after halt is first sampled negated, the status is low and `resume` is high for one clock.
- R10: `proto_err` is high for one clock in the clock after a clock edge at which `sterm_n` and at least one `ack_n` line are both low.
- R11: `early_warn` is high for one clock after the first even strobe of a cycle when acknowledge or bus-error is asserted at that strobe and neither has been negated since the previous outcome. A clean first sample gives no warning.
- R12: While `rst` is high and after it is released, all outputs are low until an input causes one of the events above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_start | input | 1 | Pulse marking the start of a new bus cycle |
| even_stb | input | 1 | Pulse marking the rising edge of an even bus state |
| ack_n | input | ACK_W | Data-transfer acknowledge lines, active low; any low line counts as asserted |
| berr_n | input | 1 | Bus error, active low |
| halt_n | input | 1 | Halt, active low |
| sterm_n | input | 1 | Synchronous terminate, active low |
| outcome | output | 4 | One-hot outcome (bit 0 continue, 1 halt stall, 2 bus error, 3 retry) |
| outcome_vld | output | 1 | One-clock strobe qualifying `outcome` |
| stall_pend | output | 1 | Halt stall waiting for halt release |
| retry_pend | output | 1 | Retry waiting for halt release |
| resume | output | 1 | One-clock pulse when a pending stall or retry is released |
| proto_err | output | 1 | Synchronous terminate and acknowledge asserted together |
| early_warn | output | 1 | Leftover termination seen at the first sample of a new cycle |

## Verification
The bench targets the two late patterns. In these, bus-error, or bus-error with halt, turns up only at N+2. A classifier that looked only at the N+2 sample, or only at N, would report continue or nothing instead of bus error or retry. A wait-state sequence shows whether the reference sample slides forward. A design that cleared it, or kept the oldest sample, would either miss the termination or fire one strobe early. The halt release is timed to the clock, so a pending status that dropped early, or a resume pulse that lasted two clocks, shows at the ports. The leftover-signal warning is tested both when it should fire and on a clean cycle, where a warning that keyed on acknowledge alone would fire falsely.

// File: rtl/bus_term_resolver.sv
module bus_term_resolver #(
  parameter int ACK_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_start,
  input  logic             even_stb,
  input  logic [ACK_W-1:0] ack_n,
  input  logic             berr_n,
  input  logic             halt_n,
  input  logic             sterm_n,
  output logic [3:0]       outcome,
  output logic             outcome_vld,
  output logic             stall_pend,
  output logic             retry_pend,
  output logic             resume,
  output logic             proto_err,
  output logic             early_warn
);

  localparam int OC_CONT  = 0;
  localparam int OC_HALT  = 1;
  localparam int OC_BERR  = 2;
  localparam int OC_RETRY = 3;

  wire ack  = ~&ack_n;
  wire berr = ~berr_n;
  wire halt = ~halt_n;
  wire term_sync = ~sterm_n;

  logic armed, have_prev, linger;
  logic p_ack, p_berr, p_halt;

  wire pending = stall_pend | retry_pend;

  wire hit_retry = (p_berr & p_halt & berr & halt) |
                   (p_ack & ~p_berr & ~p_halt & berr & halt);
  wire hit_berr  = (p_berr & ~p_halt & berr & ~halt) |
                   (p_ack & ~p_berr & ~p_halt & berr & ~halt);
  wire hit_halt  = p_ack & ack & ~p_berr & ~berr & halt;
  wire hit_cont  = p_ack & ack & ~p_berr & ~berr & ~p_halt & ~halt;

  logic [3:0] pick;
  always_comb begin
    pick = '0;
    if (hit_retry)     pick[OC_RETRY] = 1'b1;
    else if (hit_berr) pick[OC_BERR]  = 1'b1;
    else if (hit_halt) pick[OC_HALT]  = 1'b1;
    else if (hit_cont) pick[OC_CONT]  = 1'b1;
  end

  wire sample = even_stb & armed & ~cyc_start;
  wire term   = sample & have_prev & (|pick);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed       <= 1'b0;
      have_prev   <= 1'b0;
      linger      <= 1'b0;
      p_ack       <= 1'b0;
      p_berr      <= 1'b0;
      p_halt      <= 1'b0;
      outcome     <= '0;
      outcome_vld <= 1'b0;
      stall_pend  <= 1'b0;
      retry_pend  <= 1'b0;
      resume      <= 1'b0;
      proto_err   <= 1'b0;
      early_warn  <= 1'b0;
    end else begin
      outcome_vld <= 1'b0;
      outcome     <= '0;
      resume      <= 1'b0;
      early_warn  <= 1'b0;
      proto_err   <= ack & term_sync;

      if (cyc_start && !pending) begin
        armed     <= 1'b1;
        have_prev <= 1'b0;
      end else if (sample) begin
        if (term) begin
          outcome_vld <= 1'b1;
          outcome     <= pick;
          armed       <= 1'b0;
          have_prev   <= 1'b0;
          stall_pend  <= pick[OC_HALT];
          retry_pend  <= pick[OC_RETRY];
        end else begin
          p_ack     <= ack;
          p_berr    <= berr;
          p_halt    <= halt;
          have_prev <= 1'b1;
          if (!have_prev && linger && (ack || berr)) early_warn <= 1'b1;
        end
      end

      if (term) linger <= 1'b1;
      else if (!ack && !berr) linger <= 1'b0;

      if (pending && !halt) begin
        stall_pend <= 1'b0;
        retry_pend <= 1'b0;
        resume     <= 1'b1;
      end
    end
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    outcome_vld |-> $countones(outcome) == 1);
  p_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !outcome_vld |-> outcome == 4'b0);
  p_after_stb_r1: assert property (@(posedge clk) disable iff (rst)
    outcome_vld |-> $past(even_stb));
  p_pend_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(stall_pend && retry_pend));
  p_pend_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (pending && !halt_n) |=> pending);
  p_resume_r9: assert property (@(posedge clk) disable iff (rst)
    resume |-> ($past(stall_pend || retry_pend) && $past(halt_n) && !pending));
  p_proto_r10: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> $past(!sterm_n && !(&ack_n)));
  p_warn_r11: assert property (@(posedge clk) disable iff (rst)
    early_warn |-> $past(even_stb && (!(&ack_n) || !berr_n)));

endmodule

// File: tb/bus_term_resolver_test.sv
module bus_term_resolver_test;
  localparam int CLK_PERIOD = 10;
  localparam int ACK_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 1'b0, even_stb = 1'b0;
  logic [ACK_W-1:0] ack_n = '1;
  logic berr_n = 1'b1, halt_n = 1'b1, sterm_n = 1'b1;
  logic [3:0] outcome;
  logic outcome_vld, stall_pend, retry_pend, resume, proto_err, early_warn;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_q[$];
  string tag_q[$];

  bus_term_resolver #(.ACK_W(ACK_W)) uut (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .even_stb(even_stb),
    .ack_n(ack_n), .berr_n(berr_n), .halt_n(halt_n), .sterm_n(sterm_n),
    .outcome(outcome), .outcome_vld(outcome_vld), .stall_pend(stall_pend),
    .retry_pend(retry_pend), .resume(resume), .proto_err(proto_err),
    .early_warn(early_warn));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && outcome_vld) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected outcome actual=%0h expected=none", outcome);
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (outcome !== e) begin
          errors++;
          $display("FAIL %s outcome actual=%0h expected=%0h", t, outcome, e);
        end
      end
    end
  end

  task automatic start_cycle();
    @(negedge clk) cyc_start = 1'b1;
    @(negedge clk) cyc_start = 1'b0;
  endtask

  task automatic strobe(input logic a, input logic b, input logic h,
                        input logic [3:0] exp, input string tag);
    @(negedge clk);
    ack_n = a ? 2'b10 : 2'b11;
    berr_n = ~b;
    halt_n = ~h;
    even_stb = 1'b1;
    if (exp != 4'b0) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    @(negedge clk) even_stb = 1'b0;
  endtask

  task automatic idle(input logic keep_halt);
    ack_n = '1;
    berr_n = 1'b1;
    if (!keep_halt) halt_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pair(input logic a0, input logic b0, input logic h0,
                      input logic a1, input logic b1, input logic h1,
                      input logic [3:0] exp, input string tag);
    start_cycle();
    strobe(a0, b0, h0, 4'b0, tag);
    strobe(a1, b1, h1, exp, tag);
  endtask

  task automatic release_halt(input logic is_retry, input string tag);
    repeat (3) @(negedge clk);
    check({tag, " pending held"}, {6'b0, retry_pend, stall_pend}, is_retry ? 8'd2 : 8'd1);
    halt_n = 1'b1;
    @(negedge clk);
    check({tag, " resume"}, {5'b0, resume, retry_pend, stall_pend}, 8'd4);
    @(negedge clk);
    check({tag, " resume one clock"}, {7'b0, resume}, 8'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset outputs", {outcome, outcome_vld, stall_pend, retry_pend, resume}, 8'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R12 after reset", {proto_err, early_warn, outcome_vld, stall_pend, retry_pend, 3'b0}, 8'd0);

    pair(1,0,0, 1,0,0, 4'b0001, "R2 continue");
    idle(0);
    pair(1,0,1, 1,0,1, 4'b0010, "R3 halt stall");
    idle(1);
    release_halt(1'b0, "R9 stall");
    pair(1,0,0, 1,0,1, 4'b0010, "R3 halt late");
    idle(1);
    release_halt(1'b0, "R9 stall late");
    pair(0,1,0, 0,1,0, 4'b0100, "R4 bus error no ack");
    idle(0);
    pair(1,1,0, 1,1,0, 4'b0100, "R4 bus error with ack");
    idle(0);
    pair(1,0,0, 0,1,0, 4'b0100, "R5 late bus error");
    idle(0);
    pair(0,1,1, 0,1,1, 4'b1000, "R6 retry");
    idle(1);
    release_halt(1'b1, "R9 retry");
    pair(1,0,0, 0,1,1, 4'b1000, "R7 late retry");
    idle(1);
    release_halt(1'b1, "R9 retry late");

    start_cycle();
    strobe(0,0,0, 4'b0, "R8");
    strobe(0,0,0, 4'b0, "R8");
    strobe(1,0,0, 4'b0, "R8");
    check("R8 no outcome during wait states", {7'b0, outcome_vld}, 8'd0);
    strobe(1,0,0, 4'b0001, "R8 sliding sample");
    idle(0);

    start_cycle();
    strobe(0,1,0, 4'b0, "R8");
    strobe(0,0,0, 4'b0, "R8");
    check("R8 dropped bus error no outcome", {7'b0, outcome_vld}, 8'd0);
    strobe(1,0,0, 4'b0, "R8");
    strobe(1,0,0, 4'b0001, "R8 after dropped error");
    idle(0);

    @(negedge clk);
    sterm_n = 1'b0;
    ack_n = 2'b01;
    @(negedge clk);
    sterm_n = 1'b1;
    ack_n = '1;
    check("R10 protocol flag", {7'b0, proto_err}, 8'd1);
    @(negedge clk);
    check("R10 flag one clock", {7'b0, proto_err}, 8'd0);
    sterm_n = 1'b0;
    @(negedge clk);
    sterm_n = 1'b1;
    check("R10 sterm alone", {7'b0, proto_err}, 8'd0);

    pair(1,0,0, 1,0,0, 4'b0001, "R2 continue before linger");
    start_cycle();
    strobe(1,0,0, 4'b0, "R11");
    check("R11 leftover ack warns", {7'b0, early_warn}, 8'd1);
    strobe(1,0,0, 4'b0001, "R11 cycle completes");
    idle(0);
    start_cycle();
    strobe(1,0,0, 4'b0, "R11");
    check("R11 clean cycle no warn", {7'b0, early_warn}, 8'd0);
    strobe(1,0,0, 4'b0001, "R11 clean completes");
    idle(0);

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 missing outcomes actual=%0d expected=0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule